// File: doc/BRIEF.md
# SPI Core Interrupt Aggregator

This unit sits next to an SPI core. It takes the core's single-cycle or level event lines and turns them into one interrupt request for the processor. Each event source has a status bit that stays set until software clears it. A per-source mask and one global gate decide whether a set status bit reaches the interrupt line. Software acknowledges an interrupt by writing back the status word it read: every 1 in that word clears the matching bit, and every 0 leaves its bit alone.

The same 32-bit register port also carries a soft-reset command. Writing the key value 0x0A to the reset offset drives a reset pulse of fixed length to the attached core. The same pulse wipes the status and mask registers. A write of any other value to that offset does nothing.

Register offsets, byte address on an 8-bit address bus:
- 0x1C: global gate, bit 31.
- 0x20: status, write-one-to-clear.
- 0x28: mask.
- 0x40: reset key.

Source bit positions:
- bit 0: mode fault.
- bit 1: slave-select fault.
- bit 2: transmit FIFO empty.
- bit 3: transmit underrun.
- bit 4: receive FIFO full.
- bit 5: receive overrun.
- bit 6: transmit FIFO half empty.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status, mask and global gate registers all read 0, and the interrupt and core-reset outputs are low.
- R2: A rising edge on event input i sets status bit i on the clock edge that samples it. An event input that stays high does not set the bit again after software has cleared it.
- R3: A status bit stays set, whether or not its mask bit is set, until a clear write or a soft reset removes it.
- R4: Writing a word to offset 0x20 clears exactly the status bits where the word has a 1; status bits where the word has a 0 keep their value.
- R5: If a clear write and a rising event hit the same status bit on the same edge, the bit ends up set.
- R6: Offset 0x28 holds one mask bit per source. It reads back what was written, and bits above the source count read 0. A mask of 0 keeps the interrupt low whatever the status.
- R7: Offset 0x1C stores only bit 31, the global gate. All other bits read 0. With the gate at 0 the interrupt stays low.
- R8: The interrupt output is registered. In each cycle it equals gate AND OR(status AND mask) as those registers stood in the previous cycle.
- R9: A write of 0x0A to offset 0x40 holds the core-reset output high for exactly RST_LEN cycles, starting in the cycle after the write edge. The same write clears status and mask. The global gate keeps its value.
- R10: A write of any other value to offset 0x40 produces no reset pulse and leaves status and mask unchanged.
- R11: A read of any offset other than 0x1C, 0x20 or 0x28 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Write strobe for the register port |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| events | input | NUM_SRC | Event lines from the SPI core |
| irqOut | output | 1 | Registered interrupt request |
| coreRstOut | output | 1 | Soft-reset pulse to the SPI core |

## Verification
The bench targets three races:
- A clear write that lands on the same edge as a new event. A design that lets the clear win loses that interrupt.
- An event line held high across a clear. An edge detector that does not track the level re-raises the bit at once.
- A status bit set while its mask is 0. A design that gates the latch with the mask loses the event before it can be unmasked.

It also checks the exact length of the reset pulse and that a wrong key is ignored, because a sloppy key compare would reset the core on a stray write. Last, it checks the one-cycle lag between status and interrupt, because a combinational output would show up one cycle early.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  // register offsets that software depends on
  localparam logic [7:0]  OFS_GLOBAL = 8'h1C;
  localparam logic [7:0]  OFS_STATUS = 8'h20;
  localparam logic [7:0]  OFS_ENABLE = 8'h28;
  localparam logic [7:0]  OFS_SRESET = 8'h40;
  localparam logic [31:0] SRESET_KEY = 32'h0000_000A;

  // strobes from control to datapath
  typedef struct packed {
    logic wrGlobal;
    logic wrEnable;
    logic wrClear;
    logic softClr;
  } irqStrobes_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output irqStrobes_t       strb,
  output logic              coreRst
);
  localparam int CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] pulseCnt;
  logic keyHit;
  logic selGlobal, selStatus, selEnable, selReset;

  always_comb begin
    selGlobal = regAddr == ADDR_W'(OFS_GLOBAL);
    selStatus = regAddr == ADDR_W'(OFS_STATUS);
    selEnable = regAddr == ADDR_W'(OFS_ENABLE);
    selReset  = regAddr == ADDR_W'(OFS_SRESET);
    keyHit    = regWrite && selReset && (regWdata == DATA_W'(SRESET_KEY));
  end

  // reset pulse length counter
  always_ff @(posedge clk) begin
    if (!rstN)               pulseCnt <= '0;
    else if (keyHit)         pulseCnt <= CNT_W'(RST_LEN);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign coreRst = pulseCnt != '0;

  always_comb begin
    strb.softClr  = keyHit || coreRst;
    strb.wrGlobal = regWrite && selGlobal;
    strb.wrEnable = regWrite && selEnable;
    strb.wrClear  = regWrite && selStatus;
  end
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] events,
  input  irqStrobes_t        strb,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [ADDR_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irq,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic               globalQ,
  output logic [NUM_SRC-1:0] riseVec
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] evPrev;

  always_ff @(posedge clk) begin
    if (!rstN) evPrev <= '0;
    else       evPrev <= events;
  end

  assign riseVec = events & ~evPrev;

  // per-source sticky status; a new edge beats a clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN)                            statusQ[i] <= 1'b0;
      else if (strb.softClr)                statusQ[i] <= 1'b0;
      else if (riseVec[i])                  statusQ[i] <= 1'b1;
      else if (strb.wrClear && regWdata[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             enableQ <= '0;
    else if (strb.softClr) enableQ <= '0;
    else if (strb.wrEnable) enableQ <= regWdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              globalQ <= 1'b0;
    else if (strb.wrGlobal) globalQ <= regWdata[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= globalQ && |(statusQ & enableQ);
  end

  always_comb begin
    if (regAddr == ADDR_W'(OFS_GLOBAL))      regRdata = {globalQ, {(DATA_W-1){1'b0}}};
    else if (regAddr == ADDR_W'(OFS_STATUS)) regRdata = {{PAD_W{1'b0}}, statusQ};
    else if (regAddr == ADDR_W'(OFS_ENABLE)) regRdata = {{PAD_W{1'b0}}, enableQ};
    else                                     regRdata = '0;
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int RST_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] events,
  output logic               irqOut,
  output logic               coreRstOut
);
  irqStrobes_t        strb;
  logic               softClr;
  logic [NUM_SRC-1:0] statusQ, enableQ, riseVec;
  logic               globalQ;

  assign softClr = strb.softClr;

  spi_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_LEN(RST_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .coreRst(coreRstOut)
  );

  spi_irq_datapath #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .events(events), .strb(strb), .regWdata(regWdata),
    .regAddr(regAddr), .regRdata(regRdata), .irq(irqOut), .statusQ(statusQ),
    .enableQ(enableQ), .globalQ(globalQ), .riseVec(riseVec)
  );
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk
  import spi_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int RST_LEN = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic               irqOut,
  input logic               coreRstOut,
  input logic               softClr,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] riseVec,
  input logic               globalQ
);
  logic [15:0] hiCnt;
  logic keyWr, clrWr;

  assign keyWr = regWrite && regAddr == ADDR_W'(OFS_SRESET) && regWdata == DATA_W'(SRESET_KEY);
  assign clrWr = regWrite && regAddr == ADDR_W'(OFS_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN || keyWr) hiCnt <= '0;
    else if (coreRstOut) hiCnt <= hiCnt + 16'd1;
    else hiCnt <= '0;
  end

  // R8
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(globalQ && |(statusQ & enableQ)));

  // R5
  rise_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!softClr && riseVec != '0) |=> ((statusQ & $past(riseVec)) == $past(riseVec)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!softClr && !clrWr) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R9
  soft_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreRstOut |-> (statusQ == '0 && enableQ == '0));

  // R10
  pulse_needs_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstOut) |-> $past(keyWr));

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiCnt <= 16'(RST_LEN));
endmodule

bind spi_irq_unit spi_irq_unit_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_LEN(RST_LEN)
) chk_i (.*);

// File: tb/spi_irq_unit_tb_top.sv
module spi_irq_unit_tb_top;
  localparam int NV = 12;
  localparam int RLEN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [6:0]  events = '0;
  logic        irqOut, coreRstOut;

  int checks = 0;
  int fails = 0;
  bit sawPulse = 1'b0;

  always #5 clk = ~clk;

  spi_irq_unit #(.RST_LEN(RLEN)) dut_i (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .events(events),
    .irqOut(irqOut), .coreRstOut(coreRstOut)
  );

  always @(negedge clk) if (coreRstOut) sawPulse = 1'b1;

  // {req, wr, wAddr, wData, ev, rAddr, expRead, expIrq}
  localparam logic [93:0] VEC [NV] = '{
    {4'd6,  1'b1, 8'h28, 32'h0000007F, 8'h00, 8'h28, 32'h0000007F, 1'b0}, // R6 mask readback
    {4'd2,  1'b0, 8'h00, 32'h0,        8'h05, 8'h20, 32'h00000005, 1'b0}, // R2 edges, R7 gate off
    {4'd7,  1'b1, 8'h1C, 32'hFFFFFFFF, 8'h05, 8'h1C, 32'h80000000, 1'b1}, // R7 only bit31, R8
    {4'd4,  1'b1, 8'h20, 32'h00000005, 8'h05, 8'h20, 32'h00000000, 1'b0}, // R4 clear, R2 held level
    {4'd6,  1'b1, 8'h28, 32'h00000000, 8'h00, 8'h28, 32'h00000000, 1'b0}, // R6 mask zero
    {4'd3,  1'b0, 8'h00, 32'h0,        8'h30, 8'h20, 32'h00000030, 1'b0}, // R3 sticky while masked
    {4'd6,  1'b1, 8'h28, 32'hFFFFFFFF, 8'h30, 8'h28, 32'h0000007F, 1'b1}, // R6 upper bits zero
    {4'd4,  1'b1, 8'h20, 32'h00000010, 8'h00, 8'h20, 32'h00000020, 1'b1}, // R4 exact bits
    {4'd7,  1'b1, 8'h1C, 32'h7FFFFFFF, 8'h00, 8'h1C, 32'h00000000, 1'b0}, // R7 gate off
    {4'd4,  1'b1, 8'h20, 32'h00000020, 8'h00, 8'h20, 32'h00000000, 1'b0}, // R4
    {4'd11, 1'b0, 8'h00, 32'h0,        8'h00, 8'h24, 32'h00000000, 1'b0}, // R11 unmapped
    {4'd10, 1'b1, 8'h40, 32'h0000000B, 8'h01, 8'h20, 32'h00000001, 1'b0}  // R10 wrong key
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input string req, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 coreRst", {31'b0, coreRstOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    regRd("R1 status", 8'h20, 32'h0);
    regRd("R1 mask", 8'h28, 32'h0);
    regRd("R1 gate", 8'h1C, 32'h0);

    sawPulse = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [93:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vector %0d R%0d", i, v[93:90]);
      @(negedge clk);
      events = v[47:41];
      regWrite = v[89]; regAddr = v[88:81]; regWdata = v[80:49];
      @(posedge clk);
      @(negedge clk);
      regWrite = 1'b0;
      @(posedge clk);
      @(negedge clk);
      regRd(tag, v[40:33], v[32:1]);
      check({tag, " irq"}, {31'b0, irqOut}, {31'b0, v[0]});
    end
    // R10 no pulse from the wrong key
    check("R10 no pulse", {31'b0, sawPulse}, 32'h0);
    regRd("R10 mask kept", 8'h28, 32'h7F);

    // R8 one-cycle lag
    @(negedge clk) events = '0;
    regWr(8'h20, 32'h7F);
    regWr(8'h1C, 32'h80000000);
    events = 7'h40;
    @(posedge clk);
    @(negedge clk);
    regRd("R8 status set", 8'h20, 32'h40);
    check("R8 irq still low", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8 irq high", {31'b0, irqOut}, 32'h1);

    // R5 clear and edge on the same cycle
    events = 7'h00;
    @(posedge clk);
    @(negedge clk);
    regWrite = 1'b1; regAddr = 8'h20; regWdata = 32'h48; events = 7'h08;
    @(posedge clk);
    @(negedge clk);
    regWrite = 1'b0;
    regRd("R5 edge wins", 8'h20, 32'h08);

    // R9 keyed soft reset
    regWr(8'h40, 32'h0000000A);
    begin
      int hi = 0;
      check("R9 pulse starts", {31'b0, coreRstOut}, 32'h1);
      for (int k = 0; k < 8; k++) begin
        if (coreRstOut) hi++;
        @(negedge clk);
      end
      check("R9 pulse length", hi, RLEN);
    end
    regRd("R9 status wiped", 8'h20, 32'h0);
    regRd("R9 mask wiped", 8'h28, 32'h0);
    regRd("R9 gate kept", 8'h1C, 32'h80000000);
    check("R9 irq low", {31'b0, irqOut}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule